// File: doc/BRIEF.md
# SPI Flash Command Front End

This block is the serial slave that sits at the pin side of an SPI flash memory. It receives instructions on the serial input, most significant bit first in 8-bit bus cycles, and answers on the serial output in either clock polarity (idle-low or idle-high). Read-type instructions are served in the block: plain and fast memory reads streaming from a small on-chip byte array with an auto-incrementing, wrapping address, the status byte repeated, an alternating two-byte identification read and a three-byte identification sequence.

Write-type instructions (program, erase, status write and the single-byte control commands) are not executed here. The block collects their opcode, address and data bytes and hands them to a separate controller as a one-cycle request once chip select is released. The serial pins are oversampled by a faster system clock through synchronizers. The serial output is modelled as a data bit plus an output enable.

Top module: `sfl_cmd_slave`

## Requirements
- R1: SI is captured on rising SCK and SO changes only after falling SCK, both MSB first. Both idle-low and idle-high SCK work unchanged, given SCK high and low phases of at least 4 clk cycles each.
- R2: If chip select rises before the last bit of an instruction, that instruction is dropped. No request is issued and the next selection starts a fresh opcode.
- R3: Opcode 03h takes three address bytes and then streams bytes from the array. The array byte at index i is ((i mod 256) * 37) xor C3h, truncated to 8 bits.
- R4: The read address is taken from the low AW bits of the 24-bit address and increments after each byte. It wraps from 2^AW-1 to 0, and the upper address bits are ignored.
- R5: Opcode 0Bh behaves like 03h, with one ignored dummy byte between the address and the first data byte.
- R6: Opcode 05h streams the status_in byte once per bus cycle for as long as SCK runs with chip select low.
- R7: Opcodes 90h and ABh take three address bytes, then alternate between BFh and 05h. Address bit 0 equal to 1 makes 05h come first.
- R8: Opcode 9Fh, with no address, streams BFh, 25h, 05h and repeats that sequence.
- R9: so_oe is 1 only while read data is being shifted out. It is 0 during opcode, address and dummy bytes and after chip select rises.
- R10: An opcode outside the decoded set is ignored: so_oe stays 0 and no request is issued until chip select rises.
- R11: Write-type opcodes raise wreq_valid for one clk cycle after chip select rises, once all of their bytes have been received. Byte counts: 02h takes 3 address bytes and 1 data byte. ADh takes 3 address bytes and 2 data bytes. 20h, 52h and D8h take 3 address bytes. 01h takes 1 data byte. 06h, 04h, 50h, 60h, C7h, 70h, 80h and AAh take none.
- R12: wreq_opcode carries the opcode and wreq_addr the 24-bit address, which is 0 when the opcode has none. wreq_data carries the first data byte in bits 7:0 and the second in bits 15:8, with unused bytes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock |
| spi_csn | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| status_in | input | 8 | Status byte supplied by the controller |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so (0 means high impedance) |
| wreq_valid | output | 1 | One-cycle write-type request strobe |
| wreq_opcode | output | 8 | Opcode of the request |
| wreq_addr | output | 24 | Address of the request |
| wreq_data | output | 16 | Data bytes of the request |

## Verification
The assertions assume the serial pins obey the oversampling limits. SCK high and low phases each last at least four clk cycles, and chip select changes at least that far from any SCK edge, so that a request strobe always falls inside the deselected period. The stimulus drives every pin on the falling system clock. It holds each SCK phase for six cycles, changes SI only together with the falling SCK, and keeps chip select steady for whole phases. status_in is changed only while the block is deselected.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_WDATA,
    PH_OUT,
    PH_SKIP,
    PH_DONE
  } phase_t;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_STATUS,
    SRC_ID,
    SRC_JEDEC
  } src_t;

  typedef struct packed {
    logic       is_read;
    logic       is_write;
    logic       has_addr;
    logic       has_dummy;
    logic [1:0] n_wdata;
    src_t       src;
  } cmd_attr_t;

  // Content of the stand-in array at a given index
  function automatic logic [7:0] fill_byte(input logic [7:0] idx);
    return (idx * 8'd37) ^ 8'hC3;
  endfunction

  // Opcode to per-command byte layout
  function automatic cmd_attr_t decode_op(input logic [7:0] op);
    cmd_attr_t a;
    a = '0;
    case (op)
      8'h03: begin a.is_read = 1'b1; a.has_addr = 1'b1; a.src = SRC_ARRAY; end
      8'h0B: begin a.is_read = 1'b1; a.has_addr = 1'b1; a.has_dummy = 1'b1; a.src = SRC_ARRAY; end
      8'h05: begin a.is_read = 1'b1; a.src = SRC_STATUS; end
      8'h90, 8'hAB: begin a.is_read = 1'b1; a.has_addr = 1'b1; a.src = SRC_ID; end
      8'h9F: begin a.is_read = 1'b1; a.src = SRC_JEDEC; end
      8'h02: begin a.is_write = 1'b1; a.has_addr = 1'b1; a.n_wdata = 2'd1; end
      8'hAD: begin a.is_write = 1'b1; a.has_addr = 1'b1; a.n_wdata = 2'd2; end
      8'h20, 8'h52, 8'hD8: begin a.is_write = 1'b1; a.has_addr = 1'b1; end
      8'h01: begin a.is_write = 1'b1; a.n_wdata = 2'd1; end
      8'h06, 8'h04, 8'h50, 8'h60, 8'hC7, 8'h70, 8'h80, 8'hAA: a.is_write = 1'b1;
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/sfl_in_sync.sv
module sfl_in_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;

endmodule

// File: rtl/sfl_array.sv
module sfl_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(sfl_pkg::fill_byte(8'(i)));
  end

  always_ff @(posedge clk) rdata <= mem[raddr];

endmodule

// File: rtl/sfl_cmd_engine.sv
module sfl_cmd_engine
  import sfl_pkg::*;
#(
  parameter int         AW      = 8,
  parameter logic [7:0] MFR_ID  = 8'hBF,
  parameter logic [7:0] DEV_ID  = 8'h05,
  parameter logic [7:0] TYPE_ID = 8'h25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csn_q,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          si_q,
  input  logic [7:0]    status_in,
  input  logic [7:0]    arr_q,
  output logic [AW-1:0] arr_addr,
  output logic          so,
  output logic          so_oe,
  output logic          req_valid,
  output logic [7:0]    req_op,
  output logic [23:0]   req_addr,
  output logic [15:0]   req_data
);

  localparam logic [AW-1:0] A_ONE = AW'(1);

  phase_t     phase;
  cmd_attr_t  attr;
  cmd_attr_t  dec;
  logic [6:0] rx_sh;
  logic [7:0] rx_byte;
  logic [2:0] bcnt;
  logic [1:0] nbytes;
  logic [7:0] op;
  logic [23:0] addr24;
  logic [23:0] full_addr;
  logic [15:0] wdata;
  logic [AW-1:0] rd_addr;
  logic [2:0] obit;
  logic [7:0] tx_sh;
  logic [7:0] out_byte;
  logic       id_flip;
  logic [1:0] jidx;
  logic       rx_active;

  assign rx_byte   = {rx_sh, si_q};
  assign full_addr = {addr24[15:0], rx_byte};
  assign dec       = decode_op(rx_byte);
  assign arr_addr  = rd_addr;
  assign rx_active = (phase == PH_OPC) || (phase == PH_ADDR) ||
                     (phase == PH_DUMMY) || (phase == PH_WDATA);

  always_comb begin
    case (attr.src)
      SRC_ARRAY:  out_byte = arr_q;
      SRC_STATUS: out_byte = status_in;
      SRC_ID:     out_byte = id_flip ? DEV_ID : MFR_ID;
      default: begin
        case (jidx)
          2'd0:    out_byte = MFR_ID;
          2'd1:    out_byte = TYPE_ID;
          default: out_byte = DEV_ID;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_OPC;
      attr      <= '0;
      rx_sh     <= '0;
      bcnt      <= '0;
      nbytes    <= '0;
      op        <= '0;
      addr24    <= '0;
      wdata     <= '0;
      rd_addr   <= '0;
      obit      <= '0;
      tx_sh     <= '0;
      so        <= 1'b0;
      so_oe     <= 1'b0;
      id_flip   <= 1'b0;
      jidx      <= '0;
      req_valid <= 1'b0;
      req_op    <= '0;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (cs_rise) begin
        if (phase == PH_DONE && attr.is_write) begin
          req_valid <= 1'b1;
          req_op    <= op;
          req_addr  <= addr24;
          req_data  <= wdata;
        end
        phase <= PH_OPC;
        bcnt  <= '0;
        obit  <= '0;
        so_oe <= 1'b0;
      end else if (cs_fall) begin
        phase <= PH_OPC;
        bcnt  <= '0;
        obit  <= '0;
        so_oe <= 1'b0;
      end else if (!csn_q) begin
        // input side: one bit per rising SCK
        if (sck_rise && rx_active) begin
          rx_sh <= rx_byte[6:0];
          bcnt  <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            case (phase)
              PH_OPC: begin
                op     <= rx_byte;
                attr   <= dec;
                nbytes <= '0;
                addr24 <= '0;
                wdata  <= '0;
                jidx   <= '0;
                obit   <= '0;
                if (!dec.is_read && !dec.is_write) phase <= PH_SKIP;
                else if (dec.has_addr)             phase <= PH_ADDR;
                else if (dec.n_wdata != 2'd0)      phase <= PH_WDATA;
                else if (dec.is_read)              phase <= PH_OUT;
                else                               phase <= PH_DONE;
              end
              PH_ADDR: begin
                addr24 <= full_addr;
                nbytes <= nbytes + 2'd1;
                if (nbytes == 2'd2) begin
                  nbytes  <= '0;
                  rd_addr <= full_addr[AW-1:0];
                  id_flip <= rx_byte[0];
                  if (attr.has_dummy)            phase <= PH_DUMMY;
                  else if (attr.n_wdata != 2'd0) phase <= PH_WDATA;
                  else if (attr.is_read)         phase <= PH_OUT;
                  else                           phase <= PH_DONE;
                end
              end
              PH_DUMMY: phase <= PH_OUT;
              PH_WDATA: begin
                if (nbytes == 2'd0) wdata[7:0]  <= rx_byte;
                else                wdata[15:8] <= rx_byte;
                nbytes <= nbytes + 2'd1;
                if (nbytes + 2'd1 == attr.n_wdata) phase <= PH_DONE;
              end
              default: phase <= phase;
            endcase
          end
        end
        // output side: one bit per falling SCK
        if (sck_fall && phase == PH_OUT) begin
          obit <= obit + 3'd1;
          if (obit == 3'd0) begin
            so    <= out_byte[7];
            tx_sh <= {out_byte[6:0], 1'b0};
            so_oe <= 1'b1;
            case (attr.src)
              SRC_ARRAY: rd_addr <= rd_addr + A_ONE;
              SRC_ID:    id_flip <= ~id_flip;
              SRC_JEDEC: jidx    <= (jidx == 2'd2) ? 2'd0 : jidx + 2'd1;
              default:   jidx    <= jidx;
            endcase
          end else begin
            so    <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/sfl_cmd_slave.sv
module sfl_cmd_slave #(
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MFR_ID      = 8'hBF,
  parameter logic [7:0] DEV_ID      = 8'h05,
  parameter logic [7:0] TYPE_ID     = 8'h25
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        spi_sck,
  input  logic        spi_csn,
  input  logic        spi_si,
  input  logic [7:0]  status_in,
  output logic        spi_so,
  output logic        spi_so_oe,
  output logic        wreq_valid,
  output logic [7:0]  wreq_opcode,
  output logic [23:0] wreq_addr,
  output logic [15:0] wreq_data
);

  // bit order of the synchronized bundle
  localparam int B_CSN = 2;
  localparam int B_SCK = 1;
  localparam int B_SI  = 0;

  logic [2:0] sync_q, sync_rise, sync_fall;
  logic       csn_q, cs_rise, cs_fall, sck_rise, sck_fall, si_q;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_q;
  logic          unused_sync;

  sfl_in_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_csn, spi_sck, spi_si}),
    .q   (sync_q),
    .rise(sync_rise),
    .fall(sync_fall)
  );

  assign csn_q    = sync_q[B_CSN];
  assign cs_rise  = sync_rise[B_CSN];
  assign cs_fall  = sync_fall[B_CSN];
  assign sck_rise = sync_rise[B_SCK];
  assign sck_fall = sync_fall[B_SCK];
  assign si_q     = sync_q[B_SI];
  assign unused_sync = ^{sync_q[B_SCK], sync_rise[B_SI], sync_fall[B_SI]};

  sfl_array #(
    .AW(AW),
    .DW(8)
  ) u_array (
    .clk  (clk),
    .raddr(arr_addr),
    .rdata(arr_q)
  );

  sfl_cmd_engine #(
    .AW     (AW),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID),
    .TYPE_ID(TYPE_ID)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .csn_q    (csn_q),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si_q     (si_q),
    .status_in(status_in),
    .arr_q    (arr_q),
    .arr_addr (arr_addr),
    .so       (spi_so),
    .so_oe    (spi_so_oe),
    .req_valid(wreq_valid),
    .req_op   (wreq_opcode),
    .req_addr (wreq_addr),
    .req_data (wreq_data)
  );

endmodule

// File: rtl/sfl_cmd_slave_chk.sv
module sfl_cmd_slave_chk (
  input logic clk,
  input logic rst,
  input logic csn_q,
  input logic sck_fall,
  input logic so,
  input logic so_oe,
  input logic wreq_valid
);

  // R9: deselection turns the output driver off
  a_r9_oe_off_when_deselected: assert property (
    @(posedge clk) disable iff (rst) csn_q |=> !so_oe
  );

  // R9 / R1: the driver only turns on as a result of a falling SCK
  a_r9_oe_on_after_fall: assert property (
    @(posedge clk) disable iff (rst) $rose(so_oe) |-> $past(sck_fall)
  );

  // R1: the driven bit holds between falling SCK events
  a_r1_so_moves_on_fall: assert property (
    @(posedge clk) disable iff (rst) (so_oe && !sck_fall) |=> $stable(so)
  );

  // R11: a request is a single-cycle strobe
  a_r11_req_single_cycle: assert property (
    @(posedge clk) disable iff (rst) wreq_valid |=> !wreq_valid
  );

  // R2 / R11: requests appear only while deselected
  a_r2_req_while_deselected: assert property (
    @(posedge clk) disable iff (rst) wreq_valid |-> csn_q
  );

endmodule

bind sfl_cmd_slave sfl_cmd_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .csn_q     (csn_q),
  .sck_fall  (sck_fall),
  .so        (spi_so),
  .so_oe     (spi_so_oe),
  .wreq_valid(wreq_valid)
);

// File: tb/sfl_cmd_slave_tb.sv
`timescale 1ns/1ps
module sfl_cmd_slave_tb_top;

  localparam int AW = 8;
  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        csn = 1'b1;
  logic        si  = 1'b0;
  logic [7:0]  status_in = 8'h00;
  logic        so, so_oe, wreq_valid;
  logic [7:0]  wreq_opcode;
  logic [23:0] wreq_addr;
  logic [15:0] wreq_data;

  int n_tests = 0;
  int n_fail  = 0;
  int req_cnt = 0;
  bit finished = 0;
  bit mode3 = 0;
  logic [7:0]  cap_op;
  logic [23:0] cap_addr;
  logic [15:0] cap_data;

  always #2.5 clk = ~clk;

  sfl_cmd_slave dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_si(si),
    .status_in(status_in), .spi_so(so), .spi_so_oe(so_oe),
    .wreq_valid(wreq_valid), .wreq_opcode(wreq_opcode),
    .wreq_addr(wreq_addr), .wreq_data(wreq_data)
  );

  always @(posedge clk) begin
    if (!rst && wreq_valid) begin
      req_cnt++;
      cap_op   <= wreq_opcode;
      cap_addr <= wreq_addr;
      cap_data <= wreq_data;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fill(input logic [7:0] i);
    return (i * 8'd37) ^ 8'hC3;
  endfunction

  function automatic bit has_addr(input logic [7:0] op);
    return op inside {8'h03, 8'h0B, 8'h90, 8'hAB, 8'h02, 8'hAD, 8'h20, 8'h52, 8'hD8};
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] op, input logic [23:0] a, input int k);
    logic [AW-1:0] idx;
    idx = a[AW-1:0] + AW'(k);
    case (op)
      8'h03, 8'h0B: return fill(8'(idx));
      8'h05:        return status_in;
      8'h90, 8'hAB: return (a[0] ^ k[0]) ? 8'h05 : 8'hBF;
      default:      return (k % 3 == 0) ? 8'hBF : ((k % 3 == 1) ? 8'h25 : 8'h05);
    endcase
  endfunction

  task automatic begin_txn(input bit m3);
    mode3 = m3;
    sck = m3;
    tick(HP);
    csn = 1'b0;
    tick(HP);
  endtask

  task automatic end_txn();
    if (!mode3) sck = 1'b0;
    tick(HP);
    csn = 1'b1;
    tick(4 * HP);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx,
                      output bit any_oe, output bit all_oe);
    rx = '0; any_oe = 0; all_oe = 1;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0; si = tx[i];
      tick(HP);
      rx[i] = so;
      if (so_oe) any_oe = 1; else all_oe = 0;
      sck = 1'b1;
      tick(HP);
    end
  endtask

  task automatic run_read(input bit m3, input logic [7:0] op, input logic [23:0] a,
                          input int n, input string tag);
    logic [7:0] r; bit any, all, in_oe;
    begin_txn(m3);
    xfer(op, 8, r, any, all); in_oe = any;
    if (has_addr(op)) begin
      xfer(a[23:16], 8, r, any, all); in_oe |= any;
      xfer(a[15:8],  8, r, any, all); in_oe |= any;
      xfer(a[7:0],   8, r, any, all); in_oe |= any;
    end
    if (op == 8'h0B) begin
      xfer(8'hA5, 8, r, any, all); in_oe |= any;
    end
    chk("R9 oe low on input bytes", 32'(in_oe), 0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r, any, all);
      chk(tag, 32'(r), 32'(exp_read(op, a, k)));
      chk("R9 oe high on output byte", 32'(all), 1);
    end
    end_txn();
    chk("R9 oe low after deselect", 32'(so_oe), 0);
  endtask

  task automatic run_write(input bit m3, input logic [7:0] op, input logic [23:0] a,
                           input int nd, input logic [15:0] d);
    logic [7:0] r; bit any, all; int c0;
    logic [15:0] expd;
    c0 = req_cnt;
    begin_txn(m3);
    xfer(op, 8, r, any, all);
    if (has_addr(op)) begin
      xfer(a[23:16], 8, r, any, all);
      xfer(a[15:8],  8, r, any, all);
      xfer(a[7:0],   8, r, any, all);
    end
    if (nd > 0) xfer(d[7:0], 8, r, any, all);
    if (nd > 1) xfer(d[15:8], 8, r, any, all);
    end_txn();
    expd = (nd == 0) ? 16'h0 : ((nd == 1) ? {8'h00, d[7:0]} : d);
    chk("R11 one request", 32'(req_cnt - c0), 1);
    chk("R12 opcode", 32'(cap_op), 32'(op));
    chk("R12 address", 32'(cap_addr), has_addr(op) ? 32'(a) : 0);
    chk("R12 data", 32'(cap_data), 32'(expd));
  endtask

  initial begin : main
    logic [7:0] r; bit any, all; int c0;
    int unsigned seed_set;
    seed_set = $urandom(32'h51F1);
    tick(5);
    chk("R9 reset oe", 32'(so_oe), 0);
    chk("R11 reset strobe", 32'(wreq_valid), 0);
    rst = 1'b0;
    tick(10);

    // R1: both clock polarities, R3 plain read
    run_read(0, 8'h03, 24'h000010, 4, "R1 R3 read idle-low");
    run_read(1, 8'h03, 24'h000010, 4, "R1 R3 read idle-high");
    // R4: wrap and ignored upper bits
    run_read(0, 8'h03, 24'hABCDFE, 4, "R4 wrap");
    run_read(1, 8'h0B, 24'h7700FF, 3, "R4 R5 fast read wrap");
    // R5
    run_read(0, 8'h0B, 24'h000042, 3, "R5 fast read");
    // R6
    status_in = 8'h9C;
    run_read(1, 8'h05, 24'h0, 4, "R6 status stream");
    // R7
    run_read(0, 8'h90, 24'h000000, 4, "R7 id a0=0");
    run_read(1, 8'hAB, 24'h000001, 4, "R7 id a0=1");
    // R8
    run_read(0, 8'h9F, 24'h0, 7, "R8 jedec");

    // R11 / R12 write-type requests
    run_write(0, 8'h02, 24'h123456, 1, 16'h00E7);
    run_write(1, 8'hAD, 24'h0A0B0C, 2, 16'h3C5A);
    run_write(0, 8'h20, 24'hFEDCBA, 0, 16'h0);
    run_write(1, 8'h01, 24'h0, 1, 16'h0081);
    run_write(0, 8'h06, 24'h0, 0, 16'h0);
    run_write(1, 8'hC7, 24'h0, 0, 16'h0);

    // R2: abort inside data byte
    c0 = req_cnt;
    begin_txn(0);
    xfer(8'h02, 8, r, any, all);
    xfer(8'h00, 8, r, any, all);
    xfer(8'h00, 8, r, any, all);
    xfer(8'h10, 8, r, any, all);
    xfer(8'hFF, 5, r, any, all);
    end_txn();
    chk("R2 abort in data", 32'(req_cnt - c0), 0);
    // R2: abort inside opcode
    begin_txn(1);
    xfer(8'h06, 7, r, any, all);
    end_txn();
    chk("R2 abort in opcode", 32'(req_cnt - c0), 0);
    // R2: aborted read address, next command starts fresh
    begin_txn(0);
    xfer(8'h03, 8, r, any, all);
    xfer(8'h00, 8, r, any, all);
    end_txn();
    run_read(1, 8'h03, 24'h000033, 2, "R2 fresh after abort");

    // R10: unknown opcode
    c0 = req_cnt;
    begin_txn(0);
    xfer(8'h3C, 8, r, any, all);
    xfer(8'h00, 8, r, any, all);
    chk("R10 oe stays low", 32'(any), 0);
    xfer(8'h00, 8, r, any, all);
    chk("R10 oe stays low", 32'(any), 0);
    end_txn();
    chk("R10 no request", 32'(req_cnt - c0), 0);

    // random mix of read-type commands
    for (int t = 0; t < 14; t++) begin
      logic [7:0] op;
      logic [23:0] a;
      int sel;
      sel = $urandom_range(5, 0);
      a = 24'($urandom);
      status_in = 8'($urandom);
      case (sel)
        0: op = 8'h03;
        1: op = 8'h0B;
        2: op = 8'h05;
        3: op = 8'h90;
        4: op = 8'hAB;
        default: op = 8'h9F;
      endcase
      run_read(1'($urandom_range(1, 0)), op, a, $urandom_range(5, 1), "R3 R5 R6 R7 R8 random read");
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule